// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit assembled from a row of identical one-bit slices. Every slice can invert either of its operand bits and holds a full adder plus a four-way result selector. The carry ripples from the lowest slice upward. The most significant slice is a variant that also derives the overflow condition and exports its adder sum bit as the comparison outcome.

A 4-bit control word drives every slice in the same way. Bit 3 inverts operand a. Bit 2 inverts operand b and also injects a carry of 1 into slice 0. Bits 1:0 choose the slice output. With these controls the one datapath yields AND, OR, addition, two's-complement subtraction, NOR (by De Morgan's law) and set-on-less-than. No subtractor or comparator exists apart from the slices. The zero flag lets a subtract serve as an equality test for branch decisions. The overflow flag reports signed overflow of the adder.

Top module: `alu_bitslice`

## Requirements
- R1: Control 0000 gives result = a AND b.
- R2: Control 0001 gives result = a OR b.
- R3: Control 0010 gives result = (a + b) mod 2^32, with the carry rippling across all 32 bits.
- R4: Control 0110 gives result = (a - b) mod 2^32, computed as a + ~b + 1.
- R5: Control 0111 (set-on-less-than) gives result bits 31:1 = 0 and bit 0 = bit 31 of the 32-bit value a + ~b + 1. This is the raw sign bit of the difference, with no overflow correction.
- R6: Control 1100 gives result = NOR of a and b.
- R7: zero_o is 1 exactly when all 32 result bits are 0.
- R8: When bits 1:0 of the control word are 10, ovf_o is 1 exactly when the carry into bit 31 of the adder differs from the carry out of bit 31. For every other value of bits 1:0, ovf_o is 0.
- R9: Every other control code is decoded literally. Bit 3 set means operand x = ~a, otherwise x = a. Bit 2 set means y = ~b with a carry-in of 1, otherwise y = b with a carry-in of 0. Bits 1:0 select the result: 00 gives x AND y, 01 gives x OR y, 10 gives x + y + carry-in, and 11 gives 31 zero bits above bit 31 of that sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| ctrl_i | input | 4 | {invert a, negate b, result select[1:0]} |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | All result bits are zero |
| ovf_o | output | 1 | Signed overflow of the adder, valid for select 10 |

## Verification
The block holds no state, so result_o, zero_o and ovf_o are all due in the same cycle as the operands and control word that produce them. No register stands between input and output. The only delay is the ripple through 32 carry stages and the feedback of the top sum bit into slice 0. The bench changes its inputs on the falling clock edge and samples all three outputs 1 ns later, well before the next rising edge. Every sample therefore sees the settled response to that input set and nothing else.

// File: rtl/alu_bs_pkg.sv
package alu_bs_pkg;
  localparam int unsigned CTRL_W = 4;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  typedef struct packed {
    logic inv_a;
    logic neg_b;
    sel_e sel;
  } ctrl_t;

  // {carry, sum}
  function automatic logic [1:0] full_add(logic x, logic y, logic c);
    return {(x & y) | (x & c) | (y & c), x ^ y ^ c};
  endfunction

  function automatic logic pick(sel_e sel, logic x, logic y, logic s, logic less);
    case (sel)
      SEL_AND: return x & y;
      SEL_OR:  return x | y;
      SEL_SUM: return s;
      default: return less;
    endcase
  endfunction
endpackage

// File: rtl/alu_bs_slice.sv
module alu_bs_slice
  import alu_bs_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic inv_a_i,
  input  logic neg_b_i,
  input  logic carry_i,
  input  logic less_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic carry_o
);
  logic x, y, s;

  always_comb begin
    x = a_i ^ inv_a_i;
    y = b_i ^ neg_b_i;
    {carry_o, s} = full_add(x, y, carry_i);
    res_o = pick(sel_i, x, y, s, less_i);
  end
endmodule

// File: rtl/alu_bs_slice_msb.sv
module alu_bs_slice_msb
  import alu_bs_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic inv_a_i,
  input  logic neg_b_i,
  input  logic carry_i,
  input  logic less_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic set_o,
  output logic ovf_o
);
  logic x, y, s, cout;

  always_comb begin
    x = a_i ^ inv_a_i;
    y = b_i ^ neg_b_i;
    {cout, s} = full_add(x, y, carry_i);
    res_o = pick(sel_i, x, y, s, less_i);
    set_o = s;
    ovf_o = carry_i ^ cout;
  end
endmodule

// File: rtl/alu_bs_zero.sv
module alu_bs_zero #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_bs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [W-1:0]      result_o,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = W - 1;

  ctrl_t ctrl;
  logic  set_msb;
  logic  ovf_raw;

  assign ctrl = ctrl_t'(ctrl_i);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic cin;
    logic less;

    if (i == 0) begin : g_c0
      assign cin  = ctrl.neg_b;
      assign less = set_msb;
    end else begin : g_cn
      assign cin  = g_bit[i-1].g_lo.cout;
      assign less = 1'b0;
    end

    if (i < MSB) begin : g_lo
      logic cout;
      alu_bs_slice u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .inv_a_i (ctrl.inv_a),
        .neg_b_i (ctrl.neg_b),
        .carry_i (cin),
        .less_i  (less),
        .sel_i   (ctrl.sel),
        .res_o   (result_o[i]),
        .carry_o (cout)
      );
    end else begin : g_hi
      alu_bs_slice_msb u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .inv_a_i (ctrl.inv_a),
        .neg_b_i (ctrl.neg_b),
        .carry_i (cin),
        .less_i  (less),
        .sel_i   (ctrl.sel),
        .res_o   (result_o[i]),
        .set_o   (set_msb),
        .ovf_o   (ovf_raw)
      );
    end
  end

  // overflow only reported when the adder output is selected
  assign ovf_o = ovf_raw & (ctrl.sel == SEL_SUM);

  alu_bs_zero #(.W(W)) u_zero (
    .val_i  (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/alu_bs_chk.sv
module alu_bs_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [3:0]   ctrl_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         ovf_o
);
  logic [W-1:0] diff;
  logic [W-1:0] total;

  always_comb begin
    diff  = a_i - b_i;
    total = a_i + b_i;
    // R1
    and_op_chk: assert (ctrl_i != 4'b0000 || result_o == (a_i & b_i));
    // R2
    or_op_chk: assert (ctrl_i != 4'b0001 || result_o == (a_i | b_i));
    // R3
    add_op_chk: assert (ctrl_i != 4'b0010 || result_o == total);
    // R4
    sub_op_chk: assert (ctrl_i != 4'b0110 || result_o == diff);
    // R5
    slt_op_chk: assert (ctrl_i != 4'b0111 || result_o == {{(W-1){1'b0}}, diff[W-1]});
    // R6
    nor_op_chk: assert (ctrl_i != 4'b1100 || result_o == ~(a_i | b_i));
    // R7
    zero_flag_chk: assert (zero_o == (result_o == '0));
    // R8
    no_overflow_chk: assert (ctrl_i[1:0] == 2'b10 || !ovf_o);
    // R8
    add_overflow_chk: assert (ctrl_i != 4'b0010 ||
        ovf_o == ((a_i[W-1] == b_i[W-1]) && (total[W-1] != a_i[W-1])));
    // R9
    less_upper_chk: assert (ctrl_i[1:0] != 2'b11 || result_o[W-1:1] == '0);
  end
endmodule

bind alu_bitslice alu_bs_chk #(.W(W)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .ctrl_i   (ctrl_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/alu_bitslice_tb_top.sv
module alu_bitslice_tb_top;
  localparam int unsigned W = 32;
  localparam int unsigned N_RAND = 1000;
  localparam int unsigned N_CORNER = 7;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic [3:0]   ctrl;
  logic [W-1:0] result;
  logic         zero, ovf;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu_bitslice #(.W(W)) dut_i (
    .a_i      (a),
    .b_i      (b),
    .ctrl_i   (ctrl),
    .result_o (result),
    .zero_o   (zero),
    .ovf_o    (ovf)
  );

  function automatic logic [W-1:0] corner(int unsigned k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7fff_ffff;
      3: return 32'h8000_0000;
      4: return 32'hffff_ffff;
      5: return 32'h8000_0001;
      default: return 32'h7fff_fffe;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R9";
    endcase
  endfunction

  // reference built from integer arithmetic on the literal decode
  function automatic void model(input logic [W-1:0] ra, input logic [W-1:0] rb,
                                input logic [3:0] c, output logic [W-1:0] res,
                                output logic zf, output logic of);
    logic [W-1:0] x, y;
    logic         cin;
    logic [W:0]   s;
    logic [W-1:0] low;
    x   = c[3] ? ~ra : ra;
    y   = c[2] ? ~rb : rb;
    cin = c[2];
    s   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    low = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin};
    case (c[1:0])
      2'b00:   res = x & y;
      2'b01:   res = x | y;
      2'b10:   res = s[W-1:0];
      default: res = {{(W-1){1'b0}}, s[W-1]};
    endcase
    zf = (res == '0);
    of = (c[1:0] == 2'b10) && (low[W-1] != s[W]);
  endfunction

  task automatic check_now();
    logic [W-1:0] er;
    logic ez, eo;
    model(a, b, ctrl, er, ez, eo);
    n_checks++;
    if (result !== er) begin
      n_fail++;
      $display("FAIL %s result ctrl=%b a=%h b=%h got %h exp %h", req_of(ctrl), ctrl, a, b, result, er);
    end
    n_checks++;
    if (zero !== ez) begin
      n_fail++;
      $display("FAIL R7 zero ctrl=%b a=%h b=%h got %b exp %b", ctrl, a, b, zero, ez);
    end
    n_checks++;
    if (ovf !== eo) begin
      n_fail++;
      $display("FAIL R8 ovf ctrl=%b a=%h b=%h got %b exp %b", ctrl, a, b, ovf, eo);
    end
  endtask

  task automatic apply(logic [W-1:0] na, logic [W-1:0] nb, logic [3:0] nc);
    @(negedge clk);
    a = na;
    b = nb;
    ctrl = nc;
    #1;
    check_now();
  endtask

  function automatic logic [W-1:0] rnd_operand();
    int unsigned pick = $urandom_range(0, 3);
    if (pick == 0) return corner($urandom_range(0, N_CORNER - 1));
    return $urandom();
  endfunction

  initial begin
    void'($urandom(32'h5eed_a1b0));
    a = '0;
    b = '0;
    ctrl = '0;
    repeat (3) @(posedge clk);
    // reset-time state with all inputs low: R7 zero set, R8 no overflow
    #2;
    check_now();
    rst_ni = 1'b1;

    // directed: R3 full carry ripple, R4 equal operands give zero
    apply(32'hffff_ffff, 32'h0000_0001, 4'b0010);
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
    // R5 raw sign disagrees with signed compare: a > b but sign of a-b set
    apply(32'h7fff_ffff, 32'hffff_ffff, 4'b0111);
    apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
    // R8 signed overflow on add and on subtract
    apply(32'h7fff_ffff, 32'h0000_0001, 4'b0010);
    apply(32'h8000_0000, 32'h0000_0001, 4'b0110);

    // all 16 codes (R1..R6 listed, R9 the rest) over corner operand pairs
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < int'(N_CORNER); i++)
        for (int j = 0; j < int'(N_CORNER); j++)
          apply(corner(i), corner(j), 4'(c));

    // constrained random over all codes
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < int'(N_RAND); k++)
        apply(rnd_operand(), rnd_operand(), 4'(c));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired after 200000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule